// File: doc/BRIEF.md
# Serial ADC Frame Reader

This block is the host side of a link to a 10-bit serial converter that has only three wires: an active-low select, a shift clock and a data line coming back from the converter. A single request from the surrounding logic starts one read. The controller pulls select low and waits a programmable setup time. It then produces a fixed burst of fourteen shift-clock periods, derived from the system clock by an even divider. On each rising shift edge it samples the data line, keeps only the ten result bits, and presents them as a parallel word with a one-cycle valid strobe.

The first edges of the frame fall in the converter's sampling window, and the next edges carry null bits. The controller discards all of them. The word arrives most significant bit first. Once the burst is over, select goes high again. That resets the converter and lets it power down. A minimum select-high interval is kept before the next request is taken. The data line has no defined value outside a frame, so nothing is sampled there.

Top module: `adc_frame_rd`

## Requirements
- R1: During and after reset, with no request pending, sel_n_o is 1, sclk_o is 0, rd_ready_o is 1 and result_valid_o is 0.
- R2: A request is accepted only on a clock edge where rd_req_i and rd_ready_o are both 1, and sel_n_o falls on that edge. A request made while rd_ready_o is 0 starts no frame.
- R3: Within a frame, every high phase and every low phase of sclk_o lasts H system cycles, where H is half_period_i, or 1 when half_period_i is 0.
- R4: The first rise of sclk_o comes exactly S*H system cycles after sel_n_o falls, where S is setup_halves_i, or 1 when it is 0.
- R5: Each frame has exactly 14 rising edges of sclk_o. sclk_o is 0 whenever sel_n_o is 1.
- R6: sdata_i is sampled at each rising shift edge, numbered 1 to 14. Edges 1–2 (sampling window) and 3–4 (null bits) are discarded. Edges 5 to 14 give result_o[9] down to result_o[0].
- R7: result_valid_o is high for exactly one cycle: the cycle in which sclk_o first shows the 14th rising edge. result_o is updated only on that edge and holds its value until the next valid pulse.
- R8: sel_n_o rises on the same edge as the fall of sclk_o that ends the 14th clock, which is H cycles after that rise. It then stays high for at least G system cycles, where G is gap_cycles_i, or 1 when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_req_i | input | 1 | Read request; taken when rd_ready_o is high |
| rd_ready_o | output | 1 | Controller idle and able to accept a request |
| half_period_i | input | CW | Shift-clock half period in system cycles (0 acts as 1) |
| setup_halves_i | input | CW | Select-to-first-rise delay in half periods (0 acts as 1) |
| gap_cycles_i | input | CW | Minimum select-high time in system cycles (0 acts as 1) |
| sclk_o | output | 1 | Shift clock to the converter |
| sel_n_o | output | 1 | Active-low select to the converter |
| sdata_i | input | 1 | Serial data from the converter |
| result_o | output | RES_W | Last assembled conversion word |
| result_valid_o | output | 1 | One-cycle strobe marking a new result_o |

## Verification
The delays are fixed by the settings. sel_n_o falls on the edge that accepts the request. The first shift rise follows S*H cycles later, and every later phase lasts H cycles. The valid strobe and the new word show up on the same edge that raises sclk_o for the 14th time. Select rises H cycles after that edge. The bench samples all outputs on the falling system-clock edge and timestamps every transition with a cycle counter. Each spacing is compared against the value computed from the settings in force for that frame. A converter model in the bench follows the shift clock and returns the next bit after each rise. A scoreboard queue holds the expected word for each request, and the entry is popped on each valid strobe.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_SHIFT = 2'd2,
    ST_GAP   = 2'd3
  } rd_state_t;

  function automatic int unsigned frame_len(input int unsigned res_w,
                                            input int unsigned smpl_e,
                                            input int unsigned null_e);
    return res_w + smpl_e + null_e;
  endfunction
endpackage

// File: rtl/adc_rd_div.sv
module adc_rd_div #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_i,
  input  logic [CW-1:0] half_i,
  output logic          tick_o
);
  logic [CW-1:0] cnt;
  logic [CW-1:0] half_eff;

  assign half_eff = (half_i == '0) ? CW'(1) : half_i;
  assign tick_o   = !clr_i && (cnt >= half_eff - CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (clr_i || tick_o) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end

  // R3
  div_range_chk: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (cnt == '0));
endmodule

// File: rtl/adc_rd_capture.sv
module adc_rd_capture #(
  parameter int RES_W = 10,
  parameter int LEAD  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             sample_i,
  input  logic             sdata_i,
  output logic             last_o,
  output logic [RES_W-1:0] result_o,
  output logic             valid_o
);
  localparam int FRAME = RES_W + LEAD;
  localparam int EW    = $clog2(FRAME + 1);

  logic [EW-1:0]    ecnt;
  logic [EW-1:0]    ecnt_nx;
  logic [RES_W-1:0] shreg;
  logic [RES_W-1:0] shreg_nx;

  assign ecnt_nx = ecnt + EW'(1);
  assign last_o  = (ecnt == EW'(FRAME));

  generate
    if (RES_W > 1) begin : g_wide
      assign shreg_nx = {shreg[RES_W-2:0], sdata_i};
    end else begin : g_one
      assign shreg_nx = sdata_i;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      ecnt     <= '0;
      shreg    <= '0;
      result_o <= '0;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (start_i) begin
        ecnt <= '0;
      end else if (sample_i) begin
        ecnt <= ecnt_nx;
        if (ecnt_nx > EW'(LEAD)) shreg <= shreg_nx;
        if (ecnt_nx == EW'(FRAME)) begin
          result_o <= shreg_nx;
          valid_o  <= 1'b1;
        end
      end
    end
  end

  // R7
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);
  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> $stable(result_o));
  // R5
  edge_bound_chk: assert property (@(posedge clk) disable iff (rst)
    ecnt <= EW'(FRAME));
endmodule

// File: rtl/adc_frame_rd.sv
module adc_frame_rd
  import adc_rd_pkg::*;
#(
  parameter int RES_W      = 10,
  parameter int SMPL_EDGES = 2,
  parameter int NULL_EDGES = 2,
  parameter int CW         = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_req_i,
  output logic             rd_ready_o,
  input  logic [CW-1:0]    half_period_i,
  input  logic [CW-1:0]    setup_halves_i,
  input  logic [CW-1:0]    gap_cycles_i,
  output logic             sclk_o,
  output logic             sel_n_o,
  input  logic             sdata_i,
  output logic [RES_W-1:0] result_o,
  output logic             result_valid_o
);
  localparam int LEAD  = SMPL_EDGES + NULL_EDGES;
  localparam int FRAME = frame_len(RES_W, SMPL_EDGES, NULL_EDGES);

  rd_state_t     state;
  logic          tick;
  logic          rise;
  logic          last_edge;
  logic [CW-1:0] halves;
  logic [CW-1:0] gcnt;
  logic [CW-1:0] s_eff;
  logic [CW-1:0] g_eff;
  logic          setup_done;

  assign s_eff      = (setup_halves_i == '0) ? CW'(1) : setup_halves_i;
  assign g_eff      = (gap_cycles_i == '0) ? CW'(1) : gap_cycles_i;
  assign setup_done = (halves >= s_eff - CW'(1));
  assign rise = tick && (((state == ST_SETUP) && setup_done) ||
                         ((state == ST_SHIFT) && !sclk_o));

  adc_rd_div #(.CW(CW)) u_div (
    .clk    (clk),
    .rst    (rst),
    .clr_i  ((state == ST_IDLE) || (state == ST_GAP)),
    .half_i (half_period_i),
    .tick_o (tick)
  );

  adc_rd_capture #(.RES_W(RES_W), .LEAD(LEAD)) u_cap (
    .clk      (clk),
    .rst      (rst),
    .start_i  (state == ST_IDLE),
    .sample_i (rise),
    .sdata_i  (sdata_i),
    .last_o   (last_edge),
    .result_o (result_o),
    .valid_o  (result_valid_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      sel_n_o    <= 1'b1;
      sclk_o     <= 1'b0;
      rd_ready_o <= 1'b1;
      halves     <= '0;
      gcnt       <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          halves <= '0;
          if (rd_req_i) begin
            state      <= ST_SETUP;
            sel_n_o    <= 1'b0;
            rd_ready_o <= 1'b0;
          end
        end
        ST_SETUP: begin
          if (tick) begin
            if (setup_done) begin
              state  <= ST_SHIFT;
              sclk_o <= 1'b1;
            end else begin
              halves <= halves + CW'(1);
            end
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            if (sclk_o) begin
              sclk_o <= 1'b0;
              if (last_edge) begin
                sel_n_o <= 1'b1;
                state   <= ST_GAP;
                gcnt    <= '0;
              end
            end else begin
              sclk_o <= 1'b1;
            end
          end
        end
        default: begin
          if (gcnt >= g_eff - CW'(1)) begin
            state      <= ST_IDLE;
            rd_ready_o <= 1'b1;
          end else begin
            gcnt <= gcnt + CW'(1);
          end
        end
      endcase
    end
  end

  // R5
  sclk_idle_chk: assert property (@(posedge clk) disable iff (rst)
    sel_n_o |-> !sclk_o);
  // R2
  accept_only_ready_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(sel_n_o) |-> $past(rd_ready_o && rd_req_i));
  // R4
  setup_before_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sclk_o) |-> $past(!sel_n_o));
  // R8
  sel_rise_at_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sel_n_o) |-> $fell(sclk_o));
endmodule

// File: tb/sim_adc_frame_rd.sv
module sim_adc_frame_rd;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req = 1'b0;
  logic          ready;
  logic [CW-1:0] half_p = 8'd1;
  logic [CW-1:0] setup_h = 8'd1;
  logic [CW-1:0] gap_c = 8'd1;
  logic          sclk;
  logic          sel_n;
  logic          sdata = 1'b0;
  logic [9:0]    result;
  logic          valid;

  int n_cmp = 0;
  int n_bad = 0;

  logic [9:0] exp_q[$];
  logic [9:0] cur_word = '0;
  logic       cur_junk = 1'b0;
  int         dev_e = 0;
  int         done_cnt = 0;
  int         falls = 0;

  always #4 clk = ~clk;

  adc_frame_rd u0 (
    .clk            (clk),
    .rst            (rst),
    .rd_req_i       (req),
    .rd_ready_o     (ready),
    .half_period_i  (half_p),
    .setup_halves_i (setup_h),
    .gap_cycles_i   (gap_c),
    .sclk_o         (sclk),
    .sel_n_o        (sel_n),
    .sdata_i        (sdata),
    .result_o       (result),
    .result_valid_o (valid)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, expv);
    end
  endtask

  function automatic int eff(input logic [CW-1:0] v);
    return (v == 0) ? 1 : int'(v);
  endfunction

  // converter model: presents the bit for the next rising edge
  function automatic logic bit_for(input int e);
    if (e >= 5 && e <= 14) return cur_word[14 - e];
    if (e < 5) return cur_junk;
    return 1'b0;
  endfunction

  always @(negedge sel_n) begin
    dev_e = 0;
    sdata = bit_for(1);
  end

  always @(posedge sclk) begin
    dev_e = dev_e + 1;
    sdata = bit_for(dev_e + 1);
  end

  // monitor
  int   cyc = 0, t_fall = 0, t_tog = 0, t_selrise = 0, rises = 0, g_last = 1;
  bit   first_r = 0, hp_bad = 0, hold_bad = 0, idle_bad = 0, seen_rise = 0;
  logic p_sel = 1'b1, p_sclk = 1'b0, p_valid = 1'b0;
  logic [9:0] last_res = '0;

  always @(negedge clk) begin
    if (!rst) begin
      cyc++;
      if (p_sel && !sel_n) begin
        falls++;
        if (seen_rise)  // R8 minimum select-high time
          chk(cyc - t_selrise >= g_last, "R8 gap", cyc - t_selrise, g_last);
        t_fall = cyc; rises = 0; hp_bad = 0; first_r = 1;
      end
      if (!p_sclk && sclk) begin
        rises++;
        if (first_r) begin  // R4
          chk(cyc - t_fall == eff(setup_h) * eff(half_p), "R4 setup",
              cyc - t_fall, eff(setup_h) * eff(half_p));
          first_r = 0;
        end else if (cyc - t_tog != eff(half_p)) hp_bad = 1;
        t_tog = cyc;
      end
      if (p_sclk && !sclk) begin
        if (cyc - t_tog != eff(half_p)) hp_bad = 1;
        t_tog = cyc;
      end
      if (!p_sel && sel_n) begin
        chk(rises == 14, "R5 edge count", rises, 14);
        chk(p_sclk && !sclk, "R8 sel rise with sclk fall", int'(sclk), 0);
        chk(!hp_bad, "R3 half period", int'(hp_bad), 0);
        t_selrise = cyc; g_last = eff(gap_c); seen_rise = 1;
      end
      if (sel_n && sclk) idle_bad = 1;
      if (valid) begin
        chk(!p_valid, "R7 single pulse", int'(p_valid), 0);
        chk(rises == 14 && !p_sclk && sclk, "R7 valid timing", rises, 14);
        if (exp_q.size() == 0) begin
          chk(0, "R6 unexpected result", int'(result), -1);
        end else begin
          logic [9:0] e;
          e = exp_q.pop_front();
          chk(result == e, "R6 result word", int'(result), int'(e));
        end
        last_res = result;
        done_cnt++;
      end else if (result != last_res) begin
        hold_bad = 1;
      end
      p_sel = sel_n; p_sclk = sclk; p_valid = valid;
    end
  end

  task automatic run_frame(input logic [9:0] w, input int h, input int s,
                           input int g, input bit junk, input bit poke);
    int target;
    while (!ready) @(negedge clk);
    half_p = CW'(h); setup_h = CW'(s); gap_c = CW'(g);
    cur_word = w; cur_junk = junk;
    exp_q.push_back(w);
    target = done_cnt + 1;
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    if (poke) begin  // R2 request while busy must be ignored
      repeat (5) @(negedge clk);
      req = 1'b1;
      @(negedge clk);
      req = 1'b0;
    end
    while (done_cnt < target) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(sel_n == 1'b1 && sclk == 1'b0, "R1 lines idle", int'(sclk), 0);
    chk(ready == 1'b1 && valid == 1'b0, "R1 ready/valid", int'(ready), 1);
    rst = 1'b0;
    repeat (6) @(negedge clk);
    chk(sel_n == 1'b1 && sclk == 1'b0 && ready && !valid, "R1 idle after reset",
        int'(sel_n), 1);
    run_frame(10'h2A5, 1, 0, 0, 1'b1, 1'b0);
    run_frame(10'h000, 2, 1, 3, 1'b1, 1'b0);
    run_frame(10'h3FF, 3, 2, 5, 1'b0, 1'b0);
    run_frame(10'h155, 4, 3, 1, 1'b0, 1'b1);
    run_frame(10'h200, 1, 5, 10, 1'b1, 1'b0);
    run_frame(10'h001, 5, 1, 2, 1'b1, 1'b1);
    run_frame(10'h0F0, 0, 4, 7, 1'b0, 1'b0);
    repeat (200) @(negedge clk);
    // R2 busy requests produced no extra frames
    chk(falls == 7, "R2 frame count", falls, 7);
    chk(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);
    chk(!hold_bad, "R7 result held", int'(hold_bad), 0);
    chk(!idle_bad, "R5 sclk low while deselected", int'(idle_bad), 0);
    chk(ready && sel_n && !sclk, "R1 idle at end", int'(ready), 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule